// File: doc/BRIEF.md
# Reconfiguration Sequencing Controller

This block runs one complete swap of a reconfigurable region. When it receives a start pulse, it asks the outgoing module to pause by pulling an active-low unload request. It then waits for the module's active-low acknowledge, however long that takes. It then copies a bitstream of a given length, word by word, from a shared word memory to a 32-bit configuration write port. Each valid word on that port is marked by an active-low chip select. When the last word has been written, the block holds the region's active-low reset for a programmable number of cycles. It then releases the unload request and pulses `done`.

An application client uses the same memory. The application always has priority. In any cycle where the client requests memory, the address port belongs to the client and no bitstream read is issued in that cycle. The transfer carries on from the first word not yet sent once the client stops requesting. The memory is a plain synchronous read port: data appears one cycle after the read enable. The configuration port sees one word two cycles after its read was issued.

Top module: `reconfigSequencer`

## Requirements
- R1: After reset, `busy`=0, `done`=0, `unloadReqN`=1, `cfgCsN`=1 and `rrRstN`=1. A `startPulse` that is seen while idle latches `baseAddr` and `wordCount`. In the next cycle, `unloadReqN`=0 and `busy`=1.
- R2: While `unloadAckN` stays high, the block issues no bitstream read and writes no configuration word. There is no timeout.
- R3: The words written are the memory words at `baseAddr`, `baseAddr+1`, … `baseAddr+wordCount-1`, in that order, with none skipped and none repeated. A word appears on `cfgData` with `cfgCsN`=0 two cycles after its read is issued.
- R4: In any cycle with `appReq`=1, `memRdEn`=1 and `memAddr`=`appAddr`, whether the block is idle or busy. The block issues no bitstream read in that cycle, and the read data belongs to the client in the next cycle.
- R5: After the last word has left the port, `rrRstN` is low for exactly `RST_CYCLES` consecutive cycles (default 4). No configuration word appears once the reset has begun.
- R6: `unloadReqN` stays low throughout the reset pulse. It rises in the first cycle after the reset pulse ends.
- R7: `done` is high for exactly one cycle, the cycle in which `unloadReqN` rises. `busy` is high from the cycle after the start through the `done` cycle, and low in the cycle after.
- R8: A `startPulse` that arrives while `busy`=1 is ignored: the running transfer keeps its base address and word count.
- R9: `cfgCsN`=0 only in cycles that carry a valid bitstream word. Over one run, the number of such cycles equals `wordCount`, and cycles where the transfer pauses show `cfgCsN`=1.
- R10: With `wordCount`=0, no word is written, but the handshake, the reset pulse and `done` still take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the block |
| startPulse | input | 1 | Begin a reconfiguration (taken only when idle) |
| baseAddr | input | ADDR_W | First memory word of the bitstream |
| wordCount | input | CNT_W | Number of bitstream words |
| unloadReqN | output | 1 | Active-low pause request to the outgoing module |
| unloadAckN | input | 1 | Active-low acknowledge from the module |
| appReq | input | 1 | Application client memory read request |
| appAddr | input | ADDR_W | Application client read address |
| memRdEn | output | 1 | Memory read enable |
| memAddr | output | ADDR_W | Memory read address |
| memRdata | input | DATA_W | Memory read data, one cycle after the enable |
| cfgData | output | DATA_W | Configuration port write data |
| cfgCsN | output | 1 | Active-low configuration port select |
| rrRstN | output | 1 | Active-low reset to the reconfigurable region |
| busy | output | 1 | A reconfiguration is in progress |
| done | output | 1 | One-cycle end-of-reconfiguration pulse |

## Verification
Runs are made with no acknowledge delay, with short delays and with long delays. These show whether the block really waits on the module, and whether it starts neither reads nor writes before the acknowledge. Application bursts are placed inside a transfer, and another request is made while the block is idle. These show whether the client always wins the port, and whether the stream resumes at the unsent word without skipping or repeating one. A start pulse injected mid-transfer with a different base and count, plus runs of one word and of zero words, separate the correct behaviour from latching at the wrong moment and from off-by-one errors at the end of the stream. Every run also times the reset pulse and the release of the request.

// File: rtl/reconfigSeqPkg.sv
package reconfigSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNLOAD,
    ST_STREAM,
    ST_RESET,
    ST_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture base address and word count
    logic issue;   // issue one bitstream read this cycle
    logic rstRun;  // reset pulse in progress
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic moreWords;   // words still to be read
    logic streamIdle;  // nothing left to read, in flight or on the port
    logic rstLast;     // final cycle of the reset pulse
  } dpStatus_t;

endpackage

// File: rtl/reconfigSeqCtrl.sv
module reconfigSeqCtrl
  import reconfigSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        unloadAckN,
  input  logic        appReq,
  input  dpStatus_t   sts,
  output ctrlStrobe_t stb,
  output logic        unloadReqN,
  output logic        rrRstN,
  output logic        busy,
  output logic        done
);

  seqState_t stateQ, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (startPulse)     stateNext = ST_UNLOAD;
      ST_UNLOAD: if (!unloadAckN)    stateNext = ST_STREAM;
      ST_STREAM: if (sts.streamIdle) stateNext = ST_RESET;
      ST_RESET:  if (sts.rstLast)    stateNext = ST_FINISH;
      ST_FINISH:                     stateNext = ST_IDLE;
      default:                       stateNext = ST_IDLE;
    endcase
  end

  // the application client pre-empts any bitstream read
  always_comb begin
    stb.load   = (stateQ == ST_IDLE) && startPulse;
    stb.issue  = (stateQ == ST_STREAM) && sts.moreWords && !appReq;
    stb.rstRun = (stateQ == ST_RESET);
  end

  assign unloadReqN = !((stateQ == ST_UNLOAD) || (stateQ == ST_STREAM) || (stateQ == ST_RESET));
  assign rrRstN     = (stateQ != ST_RESET);
  assign busy       = (stateQ != ST_IDLE);
  assign done       = (stateQ == ST_FINISH);

  // R2: no progress out of the handshake until the module acknowledges
  assert_hold_unload_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_UNLOAD && unloadAckN) |=> (stateQ == ST_UNLOAD));

  // R7: completion is a single-cycle pulse
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: the reset phase is entered only once the stream has drained
  assert_reset_after_stream_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RESET && $past(stateQ) == ST_STREAM) |-> $past(sts.streamIdle));

endmodule

// File: rtl/reconfigSeqDatapath.sv
module reconfigSeqDatapath
  import reconfigSeqPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              appReq,
  input  logic [ADDR_W-1:0] appAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] cfgData,
  output logic              cfgCsN,
  output dpStatus_t         sts
);

  localparam int RST_W = $clog2(RST_CYCLES + 1);
  localparam logic [RST_W-1:0] RST_LAST = RST_W'(RST_CYCLES - 1);

  logic [ADDR_W-1:0] baseQ;
  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  issueCnt;
  logic              inFlight;
  logic [RST_W-1:0]  rstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ    <= '0;
      countQ   <= '0;
      issueCnt <= '0;
    end else if (stb.load) begin
      baseQ    <= baseAddr;
      countQ   <= wordCount;
      issueCnt <= '0;
    end else if (stb.issue) begin
      issueCnt <= issueCnt + 1'b1;
    end
  end

  // read issued this cycle -> data valid next cycle -> on the port the cycle after
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      cfgCsN   <= 1'b1;
      cfgData  <= '0;
    end else begin
      inFlight <= stb.issue;
      cfgCsN   <= !inFlight;
      if (inFlight) cfgData <= memRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rstCnt <= '0;
    else if (stb.rstRun) rstCnt <= rstCnt + 1'b1;
    else                 rstCnt <= '0;
  end

  assign memRdEn = appReq || stb.issue;
  assign memAddr = appReq ? appAddr : (baseQ + ADDR_W'(issueCnt));

  always_comb begin
    sts.moreWords  = (issueCnt < countQ);
    sts.streamIdle = !sts.moreWords && !inFlight && cfgCsN;
    sts.rstLast    = (rstCnt == RST_LAST);
  end

  // R9: a port word is always the result of a read issued two cycles earlier
  assert_cs_from_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCsN |-> $past(stb.issue, 2));

  // R4: the bitstream position does not advance while the client holds the memory
  assert_app_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (appReq && !stb.load) |=> $stable(issueCnt));

  // R3: never more reads than the requested length
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    issueCnt <= countQ);

endmodule

// File: rtl/reconfigSequencer.sv
module reconfigSequencer
  import reconfigSeqPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  wordCount,
  output logic              unloadReqN,
  input  logic              unloadAckN,
  input  logic              appReq,
  input  logic [ADDR_W-1:0] appAddr,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] cfgData,
  output logic              cfgCsN,
  output logic              rrRstN,
  output logic              busy,
  output logic              done
);

  ctrlStrobe_t stb;
  dpStatus_t   sts;

  reconfigSeqCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .unloadAckN (unloadAckN),
    .appReq     (appReq),
    .sts        (sts),
    .stb        (stb),
    .unloadReqN (unloadReqN),
    .rrRstN     (rrRstN),
    .busy       (busy),
    .done       (done)
  );

  reconfigSeqDatapath #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W),
    .RST_CYCLES (RST_CYCLES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .baseAddr  (baseAddr),
    .wordCount (wordCount),
    .appReq    (appReq),
    .appAddr   (appAddr),
    .memRdata  (memRdata),
    .memRdEn   (memRdEn),
    .memAddr   (memAddr),
    .cfgData   (cfgData),
    .cfgCsN    (cfgCsN),
    .sts       (sts)
  );

  // R5: the region reset never overlaps a port write
  assert_no_write_in_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    !rrRstN |-> cfgCsN);

  // R6: the unload request is released only right after the reset pulse
  assert_release_after_reset_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unloadReqN) |-> ($past(!rrRstN) && rrRstN));

  // R7: done coincides with the release of the request
  assert_done_with_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (unloadReqN && busy));

endmodule

// File: tb/sim_reconfigSequencer.sv
`timescale 1ns/1ps
module sim_reconfigSequencer;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int RSTC   = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startPulse = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [CNT_W-1:0]  wordCount = '0;
  logic              unloadReqN;
  logic              unloadAckN = 1'b1;
  logic              appReq = 1'b0;
  logic [ADDR_W-1:0] appAddr = '0;
  logic              memRdEn;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memRdata = '0;
  logic [DATA_W-1:0] cfgData;
  logic              cfgCsN;
  logic              rrRstN;
  logic              busy;
  logic              done;

  always #4 clk = ~clk;  // 125 MHz

  reconfigSequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .baseAddr(baseAddr),
    .wordCount(wordCount), .unloadReqN(unloadReqN), .unloadAckN(unloadAckN),
    .appReq(appReq), .appAddr(appAddr), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdata(memRdata), .cfgData(cfgData), .cfgCsN(cfgCsN), .rrRstN(rrRstN),
    .busy(busy), .done(done)
  );

  int total = 0;
  int fails = 0;

  function automatic logic [DATA_W-1:0] memWord(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: synchronous read, one cycle latency
  always @(posedge clk) if (memRdEn) memRdata <= memWord(memAddr);

  // outgoing-module model: acknowledges after ackDelay cycles of request
  int ackDelay = 0;
  int ackCnt = 0;
  always begin
    @(posedge clk); #1;
    if (!unloadReqN) begin
      if (ackCnt >= ackDelay) unloadAckN = 1'b0;
      ackCnt++;
    end else begin
      ackCnt = 0;
      unloadAckN = 1'b1;
    end
  end

  // scoreboard
  logic [DATA_W-1:0] expQ[$];
  int csSeen = 0;
  int rstLow = 0;
  logic appPend = 1'b0;
  logic [ADDR_W-1:0] appPendAddr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (appPend) check(memRdata == memWord(appPendAddr), "R4 client data", memRdata, memWord(appPendAddr));
      appPend = 1'b0;
      if (appReq) begin
        check(memRdEn && memAddr == appAddr, "R4 client owns port", {15'd0, memRdEn, memAddr}, {15'd0, 1'b1, appAddr});
        appPend = 1'b1;
        appPendAddr = appAddr;
      end
      if (!cfgCsN) begin
        csSeen++;
        check(!unloadAckN, "R2 word before ack", {31'd0, unloadAckN}, 32'd0);
        check(rstLow == 0, "R5 word after reset began", rstLow, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected word", cfgData, 0);
        end else begin
          logic [DATA_W-1:0] e;
          e = expQ.pop_front();
          check(cfgData == e, "R3 word order", cfgData, e);
        end
      end
      if (!rrRstN) begin
        rstLow++;
        check(!unloadReqN, "R6 request held in reset", {31'd0, unloadReqN}, 32'd0);
      end
    end
  end

  task automatic runReconfig(input logic [ADDR_W-1:0] base, input logic [CNT_W-1:0] cnt,
                             input int ack, input int appFrom, input int appLen, input logic poke);
    logic seenDone;
    seenDone = 1'b0;
    ackDelay = ack;
    csSeen = 0;
    rstLow = 0;
    for (int i = 0; i < int'(cnt); i++) expQ.push_back(memWord(base + ADDR_W'(i)));
    @(posedge clk); #1;
    startPulse = 1'b1; baseAddr = base; wordCount = cnt;
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); #1;
      startPulse = poke && (k == 10);
      baseAddr   = poke ? 16'h3000 : base;
      wordCount  = poke ? 16'd3 : cnt;
      appReq     = (k >= appFrom) && (k < appFrom + appLen);
      appAddr    = 16'h0F00 + ADDR_W'(k);
      @(negedge clk);
      if (k == 0) check(!unloadReqN && busy, "R1 request after start", {30'd0, unloadReqN, busy}, 32'd1);
      if (k == ack - 2 && ack >= 3)
        check(cfgCsN && !unloadReqN && !memRdEn, "R2 waiting for ack", {29'd0, cfgCsN, unloadReqN, memRdEn}, 32'd4);
      if (done) begin
        seenDone = 1'b1;
        check(rstLow == RSTC, "R5 reset pulse length", rstLow, RSTC);
        check(unloadReqN, "R6 request released with done", {31'd0, unloadReqN}, 32'd1);
        check(csSeen == int'(cnt), "R9 word count", csSeen, cnt);
        check(expQ.size() == 0, "R3 all words written", expQ.size(), 0);
        if (cnt == 0) check(csSeen == 0, "R10 empty bitstream", csSeen, 0);
        if (poke) check(csSeen == int'(cnt), "R8 start while busy ignored", csSeen, cnt);
        @(posedge clk); #1;
        appReq = 1'b0; startPulse = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R7 done single, busy drops", {30'd0, busy, done}, 32'd0);
        break;
      end
    end
    appReq = 1'b0;
    startPulse = 1'b0;
    if (!seenDone) check(1'b0, "R7 done never seen", 0, 1);
    expQ.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && unloadReqN && cfgCsN && rrRstN, "R1 reset state",
          {27'd0, busy, done, unloadReqN, cfgCsN, rrRstN}, 32'h7);
    // client access while idle (R4)
    @(posedge clk); #1 appReq = 1'b1; appAddr = 16'h0042;
    @(posedge clk); #1 appReq = 1'b0;
    @(negedge clk);
    check(!busy, "R8 idle stays idle", {31'd0, busy}, 0);
    runReconfig(16'h0010, 16'd6, 5, 10000, 0, 1'b0);   // long ack wait
    runReconfig(16'h0100, 16'd12, 0, 6, 3, 1'b0);      // client burst mid-stream
    runReconfig(16'h0180, 16'd5, 1, 3, 1, 1'b0);       // single-cycle client hit
    runReconfig(16'h0200, 16'd8, 2, 10000, 0, 1'b1);   // start while busy
    runReconfig(16'hFFFF, 16'd1, 1, 10000, 0, 1'b0);   // one word at top of memory
    runReconfig(16'h0300, 16'd0, 3, 10000, 0, 1'b0);   // empty bitstream (R10)
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule